// File: doc/BRIEF.md
# SPI Slave Transfer Engine with Buffered Receive

This block is the slave side of a four-wire serial link. An external master drives the serial clock and pulls the active-low select. While select is low, the engine shifts one byte in on the data-in pin and one byte out on the data-out pin, most significant bit first. The shift logic runs directly on the incoming serial clock, so that clock may be as fast as the bus clock. Each finished byte is handed across to the bus clock domain through a toggle synchronizer. There it lands in a receive holding register and is offered on a valid/ready stream.

The two mode inputs choose the idle level of the serial clock and which of its edges samples data. When the clock-phase input is 0, the first outgoing bit appears as soon as select falls. When it is 1, the first outgoing bit appears on the first clock edge. If a byte completes while the previous one is still unread, the new byte is dropped and a sticky overflow flag rises. The flag is cleared by a status-read strobe followed by a receive pop. The transmit byte enters through a stream port. That port refuses data (ready low) while select is active, so the byte being shifted out cannot change mid-transfer.

Back-pressure rules are as follows. On the receive side, the host holds `rx_ready` low for as long as it likes. Bytes that arrive meanwhile are counted as overflow and are not queued. On the transmit side, a byte is taken only in a cycle where `tx_valid` and `tx_ready` are both high. A later accepted byte replaces an earlier one.

Top module: `spi_slv_top`

## Requirements
- R1: While `slv_en` is 0 the engine ignores select and the serial clock: `miso_oe` stays 0 and no byte is ever delivered to the receive stream.
- R2: Whenever select is high (or the engine is disabled), `miso_oe` is 0 and `miso` is high-impedance; while select is low and `slv_en` is 1, `miso_oe` is 1.
- R3: Bits are sampled on `mosi` on the leading serial clock edge when `cpha`=0, and on the trailing edge when `cpha`=1. The idle clock level equals `cpol`. Bit 7 travels first in both directions.
- R4: With `cpha`=0, bit 7 of the transmit byte is on `miso` as soon as select falls, before any clock edge. With `cpha`=1, it appears on the first clock edge.
- R5: A byte received in full raises `rx_valid` with the byte on `rx_data`, within 6 bus clock cycles of its last sampling edge.
- R6: `rx_data` holds steady while `rx_valid` is high. A cycle with `rx_valid` and `rx_ready` both high removes the byte, so `rx_valid` is 0 in the next cycle unless a new byte lands in that same cycle.
- R7: A byte that completes while `rx_valid` is 1 and no pop is taking place sets `ovf`. The new byte is discarded and `rx_data` keeps the older byte.
- R8: `ovf` stays set until a `stat_rd` pulse is seen while it is set, followed by a receive pop. A pop with no prior status read leaves `ovf` at 1.
- R9: Select rising before the eighth sampling edge discards the partial byte without touching `rx_valid` or `ovf`. The next transfer begins again at bit 7.
- R10: `tx_ready` is 1 only while select has been high for the synchronizer delay. An accepted `tx_data` byte is the one sent in the next transfer.
- R11: Transfers are correct with a serial clock running at the bus clock frequency, with no phase relation between the two.
- R12: After reset, `rx_valid`=0, `ovf`=0, and `tx_ready`=1 while select is high. A transfer with no byte written sends 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slv_en | input | 1 | Slave engine enable |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| sclk | input | 1 | Serial clock from the master |
| ss_n | input | 1 | Active-low select |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out, high-impedance when not selected |
| miso_oe | output | 1 | Output enable of `miso` |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmit byte can be taken |
| tx_data | input | 8 | Transmit byte |
| rx_valid | output | 1 | Received byte waiting |
| rx_ready | input | 1 | Host takes the received byte |
| rx_data | output | 8 | Received byte |
| stat_rd | input | 1 | Status-read strobe, arms the overflow clear |
| ovf | output | 1 | Sticky receive overflow flag |

## Verification
On every bus cycle, the assertions check the receive-side flag logic. A pop must empty the holding register. The held byte must not change while it waits. `rx_valid` and `ovf` may rise only on a synchronized byte completion. `ovf` must not fall unless an armed pop took place. Only the bench scenarios can show the serial side: the bit order and edge choice of all four modes, the first-bit timing for each phase setting, and the discard of a partial byte on select abort. The same holds for the disabled engine, and for transfers whose serial clock runs as fast as the bus clock.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;
  localparam int unsigned DW   = 8;
  localparam int unsigned SYNC = 2;
  typedef logic [DW-1:0] byte_t;
endpackage

// File: rtl/spi_slv_tsync.sv
// Multi-flop synchronizer for a single level signal.
module spi_slv_tsync #(
  parameter int   STAGES = spi_slv_pkg::SYNC,
  parameter logic INIT   = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= INIT;
        else if (i == 0) chain[i] <= d;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_slv_shift.sv
// Serial clock domain: receive shifter, completion toggle, transmit bit select.
module spi_slv_shift #(
  parameter int DW = spi_slv_pkg::DW
) (
  input  logic          rst_n,
  input  logic          sclk,
  input  logic          cpol,
  input  logic          cpha,
  input  logic          ss_int_n,
  input  logic          mosi,
  input  logic [DW-1:0] tx_byte,
  output logic          miso_bit,
  output logic [DW-1:0] rx_hold,
  output logic          done_tgl
);
  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] LAST = CW'(DW-1);

  // Rising edge of sck_i is always the sampling edge, falling edge the drive edge.
  logic sck_i;
  logic clr;
  assign sck_i = sclk ^ cpol ^ cpha;
  assign clr   = ss_int_n | ~rst_n;

  logic [CW-1:0] rcnt;
  logic [DW-2:0] rsh;

  always_ff @(posedge sck_i or posedge clr) begin
    if (clr) begin
      rcnt <= '0;
      rsh  <= '0;
    end else begin
      rsh  <= {rsh[DW-3:0], mosi};
      rcnt <= (rcnt == LAST) ? '0 : rcnt + 1'b1;
    end
  end

  always_ff @(posedge sck_i or negedge rst_n) begin
    if (!rst_n) begin
      rx_hold  <= '0;
      done_tgl <= 1'b0;
    end else if (!ss_int_n && rcnt == LAST) begin
      rx_hold  <= {rsh, mosi};
      done_tgl <= ~done_tgl;
    end
  end

  logic [CW-1:0] dcnt;
  logic [CW-1:0] pos;

  always_ff @(negedge sck_i or posedge clr) begin
    if (clr) dcnt <= '0;
    else     dcnt <= (dcnt == LAST) ? '0 : dcnt + 1'b1;
  end

  // Phase 1 consumes one drive edge before the first bit, so it lags by one.
  always_comb begin
    if (cpha) pos = (dcnt == '0) ? LAST : dcnt - 1'b1;
    else      pos = dcnt;
    miso_bit = tx_byte[LAST - pos];
  end
endmodule

// File: rtl/spi_slv_rxq.sv
// Bus clock domain: receive holding register, full flag, overflow with armed clear.
module spi_slv_rxq #(
  parameter int DW = spi_slv_pkg::DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_done,
  input  logic [DW-1:0] rx_hold,
  input  logic          rx_ready,
  input  logic          stat_rd,
  output logic          rx_valid,
  output logic [DW-1:0] rx_data,
  output logic          ovf,
  output logic          ovf_arm
);
  logic pop;
  assign pop = rx_valid & rx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else if (byte_done && !(rx_valid && !pop)) begin
      rx_valid <= 1'b1;
      rx_data  <= rx_hold;
    end else if (pop) begin
      rx_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf     <= 1'b0;
      ovf_arm <= 1'b0;
    end else begin
      if (stat_rd && ovf) ovf_arm <= 1'b1;
      if (pop && ovf_arm) begin
        ovf     <= 1'b0;
        ovf_arm <= 1'b0;
      end
      if (byte_done && rx_valid && !pop) ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/spi_slv_top.sv
module spi_slv_top #(
  parameter int DW   = spi_slv_pkg::DW,
  parameter int SYNC = spi_slv_pkg::SYNC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slv_en,
  input  logic          cpol,
  input  logic          cpha,
  input  logic          sclk,
  input  logic          ss_n,
  input  logic          mosi,
  output logic          miso,
  output logic          miso_oe,
  input  logic          tx_valid,
  output logic          tx_ready,
  input  logic [DW-1:0] tx_data,
  output logic          rx_valid,
  input  logic          rx_ready,
  output logic [DW-1:0] rx_data,
  input  logic          stat_rd,
  output logic          ovf
);
  logic          ss_int_n;
  logic          miso_bit;
  logic [DW-1:0] rx_hold;
  logic          done_tgl;
  logic          tgl_s;
  logic          tgl_d;
  logic          byte_done;
  logic          ss_idle;
  logic [DW-1:0] tx_byte;
  logic          ovf_arm;

  assign ss_int_n = ss_n | ~slv_en;

  spi_slv_shift #(.DW(DW)) u_shift (
    .rst_n(rst_n), .sclk(sclk), .cpol(cpol), .cpha(cpha), .ss_int_n(ss_int_n),
    .mosi(mosi), .tx_byte(tx_byte), .miso_bit(miso_bit), .rx_hold(rx_hold),
    .done_tgl(done_tgl)
  );

  spi_slv_tsync #(.STAGES(SYNC), .INIT(1'b0)) u_sync_done (
    .clk(clk), .rst_n(rst_n), .d(done_tgl), .q(tgl_s)
  );

  spi_slv_tsync #(.STAGES(SYNC), .INIT(1'b1)) u_sync_ss (
    .clk(clk), .rst_n(rst_n), .d(ss_int_n), .q(ss_idle)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tgl_d <= 1'b0;
    else        tgl_d <= tgl_s;
  end
  assign byte_done = tgl_s ^ tgl_d;

  assign tx_ready = ss_idle;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    tx_byte <= '0;
    else if (tx_valid && tx_ready) tx_byte <= tx_data;
  end

  spi_slv_rxq #(.DW(DW)) u_rxq (
    .clk(clk), .rst_n(rst_n), .byte_done(byte_done), .rx_hold(rx_hold),
    .rx_ready(rx_ready), .stat_rd(stat_rd), .rx_valid(rx_valid),
    .rx_data(rx_data), .ovf(ovf), .ovf_arm(ovf_arm)
  );

  assign miso_oe = ~ss_int_n;
  assign miso    = miso_oe ? miso_bit : 1'bz;
endmodule

// File: rtl/spi_slv_chk.sv
module spi_slv_chk #(
  parameter int DW = spi_slv_pkg::DW
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_valid,
  input logic          rx_ready,
  input logic [DW-1:0] rx_data,
  input logic          ovf,
  input logic          ovf_arm,
  input logic          byte_done,
  input logic          tx_ready,
  input logic [DW-1:0] tx_byte
);
  // R6
  pop_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && !byte_done) |=> !rx_valid);

  // R6
  held_byte_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> $stable(rx_data));

  // R5
  valid_from_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) |-> $past(byte_done));

  // R7
  ovf_from_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> $past(byte_done && rx_valid));

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !(rx_valid && rx_ready && ovf_arm)) |=> ovf);

  // R10
  tx_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_ready |=> $stable(tx_byte));
endmodule

bind spi_slv_top spi_slv_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .rx_data(rx_data), .ovf(ovf), .ovf_arm(ovf_arm), .byte_done(byte_done),
  .tx_ready(tx_ready), .tx_byte(tx_byte)
);

// File: tb/tb_spi_slv_top.sv
`timescale 1ns/1ps
module tb_spi_slv_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       slv_en = 1'b1;
  logic       cpol = 1'b0;
  logic       cpha = 1'b0;
  logic       sclk = 1'b0;
  logic       ss_n = 1'b1;
  logic       mosi = 1'b0;
  wire        miso;
  logic       miso_oe;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic [7:0] tx_data = 8'h00;
  logic       rx_valid;
  logic       rx_ready = 1'b0;
  logic [7:0] rx_data;
  logic       stat_rd = 1'b0;
  logic       ovf;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  spi_slv_top dut (
    .clk(clk), .rst_n(rst_n), .slv_en(slv_en), .cpol(cpol), .cpha(cpha),
    .sclk(sclk), .ss_n(ss_n), .mosi(mosi), .miso(miso), .miso_oe(miso_oe),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .stat_rd(stat_rd), .ovf(ovf)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_wait(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic put_tx(input logic [7:0] b);
    @(posedge clk); #1;
    tx_valid = 1'b1; tx_data = b;
    @(posedge clk); #1;
    tx_valid = 1'b0;
  endtask

  task automatic pop();
    @(posedge clk); #1;
    rx_ready = 1'b1;
    @(posedge clk); #1;
    rx_ready = 1'b0;
  endtask

  task automatic status_read();
    @(posedge clk); #1;
    stat_rd = 1'b1;
    @(posedge clk); #1;
    stat_rd = 1'b0;
  endtask

  // Master model: nbits clock periods, then select released.
  task automatic xfer(input logic [7:0] m, input int half, input int nbits, output logic [7:0] got);
    got = 8'h00;
    sclk = cpol;
    #(half);
    ss_n = 1'b0;
    #(half);
    for (int i = 7; i > 7 - nbits; i--) begin
      if (!cpha) begin
        mosi = m[i];
        #(half);
        got[i] = miso;
        sclk = ~cpol;
        #(half);
        sclk = cpol;
      end else begin
        sclk = ~cpol;
        mosi = m[i];
        #(half);
        got[i] = miso;
        sclk = cpol;
        #(half);
      end
    end
    #(half);
    ss_n = 1'b1;
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] got;
    logic [7:0] txb;
    logic [7:0] mb;
    bus_wait(3);
    rst_n = 1'b1;
    bus_wait(3);

    // R12 reset state
    chk(rx_valid == 1'b0, "R12 rx_valid", int'(rx_valid), 0);
    chk(ovf == 1'b0, "R12 ovf", int'(ovf), 0);
    chk(tx_ready == 1'b1, "R12 tx_ready", int'(tx_ready), 1);
    // R2 idle output enable
    chk(miso_oe == 1'b0, "R2 idle oe", int'(miso_oe), 0);

    // R12 default transmit byte is 0x00
    xfer(8'hA5, 20, 8, got);
    bus_wait(6);
    chk(got == 8'h00, "R12 default tx", int'(got), 0);
    chk(rx_valid && rx_data == 8'hA5, "R5 first byte", int'(rx_data), 'hA5);
    pop();
    chk(rx_valid == 1'b0, "R6 pop clears", int'(rx_valid), 0);

    // R10 ready falls while selected; R2 enable while selected
    ss_n = 1'b0;
    bus_wait(4);
    chk(tx_ready == 1'b0, "R10 ready low in select", int'(tx_ready), 0);
    chk(miso_oe == 1'b1, "R2 oe in select", int'(miso_oe), 1);
    ss_n = 1'b1;
    bus_wait(4);
    chk(tx_ready == 1'b1, "R10 ready back", int'(tx_ready), 1);
    chk(miso_oe == 1'b0, "R2 oe after select", int'(miso_oe), 0);

    // R3 R4 R5 R6 R10 sweep over all four modes
    for (int md = 0; md < 4; md++) begin
      cpol = md[1];
      cpha = md[0];
      for (int k = 0; k < 8; k++) begin
        txb = 8'((k * 53 + 17 + md * 11) & 255);
        mb  = 8'((k * 29 + 200 + md * 7) & 255);
        put_tx(txb);
        xfer(mb, 20, 8, got);
        bus_wait(6);
        chk(got == txb, "R3 R4 R10 miso byte", int'(got), int'(txb));
        chk(rx_valid == 1'b1, "R5 valid", int'(rx_valid), 1);
        chk(rx_data == mb, "R3 R5 rx byte", int'(rx_data), int'(mb));
        pop();
        chk(rx_valid == 1'b0, "R6 pop", int'(rx_valid), 0);
      end
    end

    // R11 serial clock at bus clock rate, modes 0 and 3
    for (int md = 0; md < 4; md += 3) begin
      cpol = md[1];
      cpha = md[0];
      for (int k = 0; k < 4; k++) begin
        txb = 8'((k * 97 + 3) & 255);
        mb  = 8'((k * 71 + 129) & 255);
        put_tx(txb);
        xfer(mb, 4, 8, got);
        bus_wait(6);
        chk(got == txb, "R11 fast miso", int'(got), int'(txb));
        chk(rx_valid && rx_data == mb, "R11 fast rx", int'(rx_data), int'(mb));
        pop();
      end
    end

    // R7 R8 overflow and its clear sequence
    cpol = 1'b0; cpha = 1'b0;
    xfer(8'h11, 20, 8, got);
    bus_wait(6);
    xfer(8'h22, 20, 8, got);
    bus_wait(6);
    chk(ovf == 1'b1, "R7 ovf set", int'(ovf), 1);
    chk(rx_data == 8'h11, "R7 old byte kept", int'(rx_data), 'h11);
    pop();
    chk(ovf == 1'b1, "R8 pop alone keeps ovf", int'(ovf), 1);
    chk(rx_valid == 1'b0, "R6 pop under ovf", int'(rx_valid), 0);
    xfer(8'h33, 20, 8, got);
    bus_wait(6);
    chk(rx_valid && rx_data == 8'h33, "R7 next byte after pop", int'(rx_data), 'h33);
    status_read();
    chk(ovf == 1'b1, "R8 status read alone keeps ovf", int'(ovf), 1);
    pop();
    bus_wait(1);
    chk(ovf == 1'b0, "R8 armed pop clears", int'(ovf), 0);

    // R9 abort mid-byte in mode 0 and mode 1
    for (int md = 0; md < 2; md++) begin
      cpol = 1'b0; cpha = md[0];
      put_tx(8'hC3);
      xfer(8'hF0, 20, 5, got);
      bus_wait(6);
      chk(rx_valid == 1'b0, "R9 no byte on abort", int'(rx_valid), 0);
      chk(ovf == 1'b0, "R9 no ovf on abort", int'(ovf), 0);
      xfer(8'h5A, 20, 8, got);
      bus_wait(6);
      chk(rx_data == 8'h5A, "R9 realigned rx", int'(rx_data), 'h5A);
      chk(got == 8'hC3, "R9 realigned tx", int'(got), 'hC3);
      pop();
    end

    // R1 disabled engine
    cpol = 1'b0; cpha = 1'b0;
    slv_en = 1'b0;
    bus_wait(4);
    ss_n = 1'b0;
    #10;
    chk(miso_oe == 1'b0, "R1 oe while disabled", int'(miso_oe), 0);
    ss_n = 1'b1;
    xfer(8'h77, 20, 8, got);
    bus_wait(6);
    chk(rx_valid == 1'b0, "R1 no byte while disabled", int'(rx_valid), 0);
    slv_en = 1'b1;
    bus_wait(4);
    xfer(8'h3C, 20, 8, got);
    bus_wait(6);
    chk(rx_valid && rx_data == 8'h3C, "R1 works after enable", int'(rx_data), 'h3C);
    pop();

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule